// File: doc/BRIEF.md
# SMI Status Aggregation Register

This block is a 32-bit power-management status word. It collects the system-management interrupt sources of a chip and turns them into one registered, active-low interrupt request. Sticky event bits stay set until software writes a one to their position. Derived bits are recomputed every cycle from external status and enable vectors. A per-bit enable vector selects which status bits may raise the request.

The SMBus event bit gets its events from a slow 64 kHz domain. Each of its four event sources passes through a multi-flop synchronizer and a rising-edge detector. The source's own qualifying controls are applied before the edge sets the bit. After the bit sets, a hold window of parameterised length protects it from being cleared, so software cannot drop it sooner than one slow-clock period.

Software reads the word on `rd_data` and writes it through `wr_en`/`wr_data`. The event generators, the periodic-rate timer and the enable register decode sit outside the block.

Top module: `smi_status_agg`

## Requirements
- R1: After synchronous reset `rd_data` is 0 and `smi_n` is 1. Bits 31:19 and 11:0 always read 0.
- R2: Bit 18 (USB group A) and bit 17 (USB group B) are updated each clock to the OR over the group of status AND enable. Each reads 0 when its group enables are all 0.
- R3: Writes have no effect on bits 18, 17, 15 and 12 or on the reserved bits.
- R4: Bit 14 is set by a one-cycle `periodic_tick` and bit 13 by a one-cycle `wdog_evt`. Writing 1 to either bit clears it on the next edge. Writing 0 leaves it unchanged.
- R5: When a set event and a write-one-to-clear reach a sticky bit (16, 14, 13) in the same cycle, the bit stays set.
- R6: Bit 16 is set within four clocks of a rising edge on a slow-domain SMBus event, provided the event is qualified. A slave message is always qualified. An alert needs `smb_smi_en`=1 and `smb_alert_dis`=0. A host notify needs `smb_notify_int_en`=1 and `smb_smi_en`=1. A link SMI command needs `in_s0`=1.
- R7: A write-one-to-clear of bit 16 is ignored during the `SMB_HOLD_CYC` clock edges that follow the edge which set it. A clear is accepted after that.
- R8: Bit 15 follows `sirq_smi_req` with one clock of delay and is not sticky.
- R9: Bit 12 is updated each clock to the OR of `trap_sts` AND `trap_en`.
- R10: `smi_n` is registered. It goes low one clock after any of bits 18:13 reads 1 with the same bit of `smi_en` set, or after bit 12 reads 1 (which needs no enable). It returns high one clock after no such bit remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, ones clear sticky bits |
| rd_data | output | 32 | Current status word |
| smi_en | input | 32 | Per-bit SMI enables, same positions as status |
| smb_slave_msg | input | 1 | Slow domain: slave message received |
| smb_alert | input | 1 | Slow domain: alert line active |
| smb_host_notify | input | 1 | Slow domain: host notify received |
| smb_link_smi | input | 1 | Slow domain: link SMI command seen |
| smb_smi_en | input | 1 | SMBus SMI enable |
| smb_alert_dis | input | 1 | Alert disable |
| smb_notify_int_en | input | 1 | Host notify interrupt enable |
| in_s0 | input | 1 | System is in the working state |
| sirq_smi_req | input | 1 | Serial IRQ decoder SMI request level |
| periodic_tick | input | 1 | Periodic timer pulse |
| wdog_evt | input | 1 | Watchdog logic event pulse |
| trap_sts | input | TRAP_W | Device trap status |
| trap_en | input | TRAP_W | Device trap enables |
| usb_a_sts | input | USB_A_W | USB group A status |
| usb_a_en | input | USB_A_W | USB group A enables |
| usb_b_sts | input | USB_B_W | USB group B status |
| usb_b_en | input | USB_B_W | USB group B enables |
| smi_n | output | 1 | Registered active-low SMI request |

## Verification
The hardest state to reach is bit 16 inside its hold window. That needs a qualified slow-domain edge that has passed the synchronizer, followed by a clear that arrives while the bit is still protected. The stimulus raises each SMBus source asynchronously, off the clock grid, and waits out the synchronizer latency. It writes a clear at once, which must be ignored, then waits past the window and clears again. Each source is first tried with its qualifying controls off, to show that the edge alone does not set the bit.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
  localparam int STS_W = 32;

  localparam int B_USB_A = 18;
  localparam int B_USB_B = 17;
  localparam int B_SMB   = 16;
  localparam int B_SIRQ  = 15;
  localparam int B_PER   = 14;
  localparam int B_WDOG  = 13;
  localparam int B_TRAP  = 12;

  localparam logic [STS_W-1:0] EN_MASK   = 32'h0007_E000;
  localparam logic [STS_W-1:0] DIR_MASK  = 32'h0000_1000;
  localparam logic [STS_W-1:0] RSVD_MASK = ~(EN_MASK | DIR_MASK);

  localparam int SMB_SRC_N = 4;
  typedef enum logic [1:0] {
    SMB_SLAVE  = 2'd0,
    SMB_ALERT  = 2'd1,
    SMB_NOTIFY = 2'd2,
    SMB_LINK   = 2'd3
  } smb_src_e;
endpackage

// File: rtl/smi_sync_edge.sv
module smi_sync_edge #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise
);
  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], async_in[i]};
        prev <= sh[LAST];
      end
    end

    assign rise[i] = sh[LAST] & ~prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);  // R6
  end
endmodule

// File: rtl/smi_w1c_bit.sv
module smi_w1c_bit #(
  parameter int HOLD_CYC = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  localparam int CNT_W = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;

  logic clr_ok;

  if (HOLD_CYC > 0) begin : g_hold
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst)             cnt <= '0;
      else if (set_i)      cnt <= CNT_W'(HOLD_CYC);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign clr_ok = (cnt == '0);

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (q_o && cnt != '0) |=> q_o);  // R7
  end else begin : g_nohold
    assign clr_ok = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                    q_o <= 1'b0;
    else if (set_i)             q_o <= 1'b1;
    else if (clr_i && clr_ok)   q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);  // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i && clr_ok) |=> !q_o);  // R4
  AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (rst)
    (!q_o && !set_i) |=> !q_o);  // R4
endmodule

// File: rtl/smi_masked_or.sv
module smi_masked_or #(
  parameter int W = 4
) (
  input  logic [W-1:0] sts,
  input  logic [W-1:0] en,
  output logic         hit
);
  assign hit = |(sts & en);
endmodule

// File: rtl/smi_status_agg.sv
module smi_status_agg
  import smi_agg_pkg::*;
#(
  parameter int TRAP_W       = 8,
  parameter int USB_A_W      = 4,
  parameter int USB_B_W      = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int SMB_HOLD_CYC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [STS_W-1:0]   wr_data,
  output logic [STS_W-1:0]   rd_data,
  input  logic [STS_W-1:0]   smi_en,
  input  logic               smb_slave_msg,
  input  logic               smb_alert,
  input  logic               smb_host_notify,
  input  logic               smb_link_smi,
  input  logic               smb_smi_en,
  input  logic               smb_alert_dis,
  input  logic               smb_notify_int_en,
  input  logic               in_s0,
  input  logic               sirq_smi_req,
  input  logic               periodic_tick,
  input  logic               wdog_evt,
  input  logic [TRAP_W-1:0]  trap_sts,
  input  logic [TRAP_W-1:0]  trap_en,
  input  logic [USB_A_W-1:0] usb_a_sts,
  input  logic [USB_A_W-1:0] usb_a_en,
  input  logic [USB_B_W-1:0] usb_b_sts,
  input  logic [USB_B_W-1:0] usb_b_en,
  output logic               smi_n
);
  localparam int STICKY_N = 3;
  localparam int STICKY_POS [STICKY_N] = '{B_SMB, B_PER, B_WDOG};

  // SMBus slow-domain events: synchronize, edge-detect, qualify.
  logic [SMB_SRC_N-1:0] smb_raw, smb_rise, smb_qual;
  logic                 smb_set;

  always_comb begin
    smb_raw             = '0;
    smb_raw[SMB_SLAVE]  = smb_slave_msg;
    smb_raw[SMB_ALERT]  = smb_alert;
    smb_raw[SMB_NOTIFY] = smb_host_notify;
    smb_raw[SMB_LINK]   = smb_link_smi;
  end

  smi_sync_edge #(.W(SMB_SRC_N), .STAGES(SYNC_STAGES)) u_smb_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (smb_raw),
    .rise     (smb_rise)
  );

  always_comb begin
    smb_qual             = '0;
    smb_qual[SMB_SLAVE]  = 1'b1;
    smb_qual[SMB_ALERT]  = smb_smi_en & ~smb_alert_dis;
    smb_qual[SMB_NOTIFY] = smb_notify_int_en & smb_smi_en;
    smb_qual[SMB_LINK]   = in_s0;
  end

  assign smb_set = |(smb_rise & smb_qual);

  // Sticky write-one-to-clear bits.
  logic [STICKY_N-1:0] sticky_set, sticky_q;

  assign sticky_set[0] = smb_set;
  assign sticky_set[1] = periodic_tick;
  assign sticky_set[2] = wdog_evt;

  for (genvar g = 0; g < STICKY_N; g++) begin : g_sticky
    smi_w1c_bit #(
      .HOLD_CYC((STICKY_POS[g] == B_SMB) ? SMB_HOLD_CYC : 0)
    ) u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (sticky_set[g]),
      .clr_i (wr_en & wr_data[STICKY_POS[g]]),
      .q_o   (sticky_q[g])
    );
  end

  // Derived, non-sticky bits.
  logic usb_a_hit, usb_b_hit, trap_hit;
  logic usb_a_q, usb_b_q, sirq_q, trap_q;

  smi_masked_or #(.W(USB_A_W)) u_usb_a (.sts(usb_a_sts), .en(usb_a_en), .hit(usb_a_hit));
  smi_masked_or #(.W(USB_B_W)) u_usb_b (.sts(usb_b_sts), .en(usb_b_en), .hit(usb_b_hit));
  smi_masked_or #(.W(TRAP_W))  u_trap  (.sts(trap_sts),  .en(trap_en),  .hit(trap_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      usb_a_q <= 1'b0;
      usb_b_q <= 1'b0;
      sirq_q  <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      usb_a_q <= usb_a_hit;
      usb_b_q <= usb_b_hit;
      sirq_q  <= sirq_smi_req;
      trap_q  <= trap_hit;
    end
  end

  // Status word assembly.
  logic [STS_W-1:0] sts_q;

  always_comb begin
    sts_q = '0;
    for (int i = 0; i < STICKY_N; i++) sts_q[STICKY_POS[i]] = sticky_q[i];
    sts_q[B_USB_A] = usb_a_q;
    sts_q[B_USB_B] = usb_b_q;
    sts_q[B_SIRQ]  = sirq_q;
    sts_q[B_TRAP]  = trap_q;
  end

  assign rd_data = sts_q;

  // Interrupt request.
  logic smi_any;
  assign smi_any = |((sts_q & smi_en & EN_MASK) | (sts_q & DIR_MASK));

  always_ff @(posedge clk) begin
    if (rst) smi_n <= 1'b1;
    else     smi_n <= ~smi_any;
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data & RSVD_MASK, smi_en & ~EN_MASK};

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSVD_MASK) == '0);  // R1
  AST_USB_A_GATED: assert property (@(posedge clk) disable iff (rst)
    (usb_a_en == '0) |=> !rd_data[B_USB_A]);  // R2
  AST_USB_B_GATED: assert property (@(posedge clk) disable iff (rst)
    (usb_b_en == '0) |=> !rd_data[B_USB_B]);  // R2
  AST_SIRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    sirq_smi_req |=> rd_data[B_SIRQ]);  // R8
  AST_SIRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !sirq_smi_req |=> !rd_data[B_SIRQ]);  // R8
  AST_TRAP_GATED: assert property (@(posedge clk) disable iff (rst)
    (trap_en == '0) |=> !rd_data[B_TRAP]);  // R9
  AST_SMI_ASSERT: assert property (@(posedge clk) disable iff (rst)
    ((rd_data & smi_en & EN_MASK) != '0 || rd_data[B_TRAP]) |=> !smi_n);  // R10
  AST_SMI_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ((rd_data & smi_en & EN_MASK) == '0 && !rd_data[B_TRAP]) |=> smi_n);  // R10
endmodule

// File: tb/test_smi_status_agg.sv
module test_smi_status_agg;
  localparam int HOLD = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] smi_en = '0;
  logic [3:0]  smb_raw = '0;
  logic        smb_smi_en = 1'b0, smb_alert_dis = 1'b0, smb_notify_int_en = 1'b0, in_s0 = 1'b0;
  logic        sirq = 1'b0, tick = 1'b0, wdog = 1'b0;
  logic [7:0]  tr_s = '0, tr_e = '0;
  logic [3:0]  ua_s = '0, ua_e = '0, ub_s = '0, ub_e = '0;
  logic        smi_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smi_status_agg #(.TRAP_W(8), .USB_A_W(4), .USB_B_W(4), .SYNC_STAGES(2), .SMB_HOLD_CYC(HOLD))
  i_smi_status_agg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .smi_en(smi_en),
    .smb_slave_msg(smb_raw[0]), .smb_alert(smb_raw[1]), .smb_host_notify(smb_raw[2]),
    .smb_link_smi(smb_raw[3]), .smb_smi_en(smb_smi_en), .smb_alert_dis(smb_alert_dis),
    .smb_notify_int_en(smb_notify_int_en), .in_s0(in_s0), .sirq_smi_req(sirq),
    .periodic_tick(tick), .wdog_evt(wdog), .trap_sts(tr_s), .trap_en(tr_e),
    .usb_a_sts(ua_s), .usb_a_en(ua_e), .usb_b_sts(ub_s), .usb_b_en(ub_e), .smi_n(smi_n)
  );

  typedef struct packed {
    logic        tick, wdog, irq;
    logic [7:0]  tr_s, tr_e;
    logic [3:0]  ua_s, ua_e, ub_s, ub_e;
    logic        wr;
    logic [31:0] wd, exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b0,32'h0,        32'h0},        // R1 idle
    '{1'b1,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b0,32'h0,        32'h4000},     // R4 tick
    '{1'b0,1'b1,1'b0,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b0,32'h0,        32'h6000},     // R4 wdog
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b1,32'h2000,     32'h4000},     // R4 clear 13
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b1,32'h0,        32'h4000},     // R4 write 0
    '{1'b1,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b1,32'h4000,     32'h4000},     // R5 set wins
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b1,32'h4000,     32'h0},        // R4 clear 14
    '{1'b0,1'b0,1'b1,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b0,32'h0,        32'h8000},     // R8
    '{1'b0,1'b0,1'b0,8'hF0,8'h0F,4'h0,4'h0,4'h0,4'h0,1'b0,32'h0,        32'h0},        // R9 mismatch
    '{1'b0,1'b0,1'b0,8'h10,8'h10,4'h0,4'h0,4'h0,4'h0,1'b0,32'h0,        32'h1000},     // R9 hit
    '{1'b0,1'b0,1'b0,8'h10,8'h10,4'h0,4'h0,4'h0,4'h0,1'b1,32'hFFFF_FFFF,32'h1000},     // R3 R1
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'hF,4'h0,4'h0,4'h0,1'b0,32'h0,        32'h0},        // R2 no en
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'h2,4'h2,4'h0,4'h0,1'b0,32'h0,        32'h40000},    // R2 A
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h8,4'h8,1'b0,32'h0,        32'h20000},    // R2 B
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h8,4'h7,1'b0,32'h0,        32'h0},        // R2 B masked
    '{1'b0,1'b1,1'b1,8'h01,8'h01,4'h1,4'h1,4'h1,4'h1,1'b0,32'h0,        32'h6B000},    // mixed
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b0,32'h0,        32'h2000},     // R8 R2 drop
    '{1'b0,1'b0,1'b0,8'h00,8'h00,4'h0,4'h0,4'h0,4'h0,1'b1,32'h2000,     32'h0}         // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic smb_pulse(input int idx);
    #1.3 smb_raw[idx] = 1'b1;
    cyc(6);
    #0.7 smb_raw[idx] = 1'b0;
    cyc(4);
  endtask

  task automatic smb_clear(input string req);
    cyc(HOLD + 2);
    wr(32'h1_0000);
    chk(req, {31'b0, rd_data[16]}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk("R1 reset rd_data", rd_data, 32'h0);
    chk("R1 reset smi_n", {31'b0, smi_n}, 32'h1);

    smi_en = 32'h0007_E000;
    prev = 32'h0;
    for (int k = 0; k < NV; k++) begin
      tick = VEC[k].tick; wdog = VEC[k].wdog; sirq = VEC[k].irq;
      tr_s = VEC[k].tr_s; tr_e = VEC[k].tr_e;
      ua_s = VEC[k].ua_s; ua_e = VEC[k].ua_e; ub_s = VEC[k].ub_s; ub_e = VEC[k].ub_e;
      wr_en = VEC[k].wr; wr_data = VEC[k].wd;
      @(negedge clk);
      chk($sformatf("R4 table rd_data entry %0d", k), rd_data, VEC[k].exp);
      chk($sformatf("R10 table smi_n entry %0d", k), {31'b0, smi_n},
          {31'b0, ((prev & 32'h7F000) == 0)});
      prev = VEC[k].exp;
    end
    tick = 0; wdog = 0; sirq = 0; tr_s = 0; tr_e = 0;
    ua_s = 0; ua_e = 0; ub_s = 0; ub_e = 0; wr_en = 0; wr_data = 0;
    cyc(2);

    // R10: enable masking of a sticky bit
    smi_en = 32'h0;
    tick = 1'b1; cyc(1); tick = 1'b0; cyc(2);
    chk("R4 tick sets bit14", rd_data, 32'h4000);
    chk("R10 masked smi_n high", {31'b0, smi_n}, 32'h1);
    smi_en = 32'h4000; cyc(2);
    chk("R10 enabled smi_n low", {31'b0, smi_n}, 32'h0);
    wr(32'h4000); cyc(1);
    chk("R10 smi_n release", {31'b0, smi_n}, 32'h1);
    chk("R4 bit14 cleared", rd_data, 32'h0);

    // R9/R10: trap bit needs no enable
    smi_en = 32'h0; tr_s = 8'h01; tr_e = 8'h01; cyc(2);
    chk("R9 trap bit", rd_data, 32'h1000);
    chk("R10 trap smi_n low without enable", {31'b0, smi_n}, 32'h0);
    tr_e = 8'h00; cyc(2);
    chk("R9 trap masked", rd_data, 32'h0);
    chk("R10 trap smi_n high", {31'b0, smi_n}, 32'h1);

    // R2/R10: derived USB bit with its smi enable off
    ua_s = 4'h4; ua_e = 4'h4; cyc(2);
    chk("R2 usb A bit", rd_data, 32'h40000);
    chk("R10 usb A masked", {31'b0, smi_n}, 32'h1);
    smi_en = 32'h40000; cyc(2);
    chk("R10 usb A enabled", {31'b0, smi_n}, 32'h0);
    ua_s = 0; ua_e = 0; smi_en = 32'h0; cyc(2);

    // R8/R3: serial IRQ bit ignores writes
    sirq = 1'b1; cyc(1);
    wr(32'h8000);
    chk("R3 write to bit15 ignored", rd_data, 32'h8000);
    smi_en = 32'h8000; cyc(1);
    chk("R10 sirq smi_n low", {31'b0, smi_n}, 32'h0);
    sirq = 1'b0; cyc(2);
    chk("R8 sirq drop", rd_data, 32'h0);
    chk("R10 sirq smi_n high", {31'b0, smi_n}, 32'h1);

    // R6/R7: SMBus slow-domain events
    smi_en = 32'h1_0000;
    smb_pulse(0);
    chk("R6 slave message sets bit16", rd_data, 32'h1_0000);
    chk("R10 smb smi_n low", {31'b0, smi_n}, 32'h0);
    wr(32'h1_0000);
    chk("R7 early clear ignored", rd_data, 32'h1_0000);
    smb_clear("R7 late clear accepted");
    cyc(1);
    chk("R10 smb smi_n high", {31'b0, smi_n}, 32'h1);

    smb_smi_en = 1'b0; smb_alert_dis = 1'b0;
    smb_pulse(1);
    chk("R6 alert without smb_smi_en", rd_data, 32'h0);
    smb_smi_en = 1'b1; smb_alert_dis = 1'b1;
    smb_pulse(1);
    chk("R6 alert disabled", rd_data, 32'h0);
    smb_alert_dis = 1'b0;
    smb_pulse(1);
    chk("R6 alert qualified", rd_data, 32'h1_0000);
    smb_clear("R7 clear after alert");

    smb_notify_int_en = 1'b0;
    smb_pulse(2);
    chk("R6 notify without int enable", rd_data, 32'h0);
    smb_notify_int_en = 1'b1;
    smb_pulse(2);
    chk("R6 notify qualified", rd_data, 32'h1_0000);
    smb_clear("R7 clear after notify");

    in_s0 = 1'b0;
    smb_pulse(3);
    chk("R6 link outside S0", rd_data, 32'h0);
    in_s0 = 1'b1;
    smb_pulse(3);
    chk("R6 link in S0", rd_data, 32'h1_0000);
    smb_clear("R7 clear after link");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule